// File: doc/BRIEF.md
# Device Operating State Controller

This block holds the life-cycle state of a device and applies a fixed set of allowed moves between five states. The states are powered off, safe, cold boot, warm boot and operational. A supply-present flag, a power-on reset and a supply-in-range monitor choose between the off and safe states. They also force the device back to safe from any running state. Three kinds of request move the device forward: a single-cycle cold-boot-done pulse, a software initialisation-complete strobe and a set of warm-reset request lines. The block does not model analog supply behaviour or the boot work itself. Each of these appears only as an input pulse.

From the current state the block drives four things: an internal warm-reset line, a CPU enable, and an I/O high-impedance control that keeps the pins input-only. It also drives a state code that other logic can observe. When a request arrives in a state that does not accept it, the block ignores the request and sets a sticky flag. Only the block reset clears that flag.

Moves take effect on the clock edge after the qualifying inputs are seen. The outputs are decoded directly from the state register, so they change in the same cycle as the state code.

Top module: `dev_lifecycle_ctrl`

## Requirements
- R1: While `rst_n` is low the state is powered off (code 0), `illegal_seen` is 0, `warm_rst` and `io_hiz` are 1 and `cpu_en` is 0.
- R2: Powered off (code 0) moves to safe when `supply_on` is 1. The powered-off state is entered only from safe, when `supply_on` is 0 in safe.
- R3: In safe (code 1) with `supply_on` high, the state holds while `por` is 1 or `vmon_ok` is 0. It moves to cold boot (code 2) on the edge where `por` is 0 and `vmon_ok` is 1.
- R4: In cold boot, warm boot or operational, any of `por`=1, `vmon_ok`=0 or `supply_on`=0 moves the state to safe on the next edge, never directly to powered off. This force takes priority over every request.
- R5: Cold boot moves to warm boot (code 3) on an edge where `cold_done` is 1 and no force of R4 is present. Otherwise it holds.
- R6: Warm boot moves to operational (code 4) only on an edge with `sw_init_done` high and no force. A warm-reset request in warm boot is accepted and keeps the state in warm boot.
- R7: In operational, any bit of `warm_req` returns the state to warm boot. It takes priority over `sw_init_done`.
- R8: `warm_rst` and `io_hiz` are 1 in powered off, safe and cold boot and 0 in warm boot and operational. `cpu_en` is 1 only in warm boot and operational.
- R9: A request is illegal in these cases: `cold_done` outside cold boot, `sw_init_done` outside warm boot, or any `warm_req` bit in powered off, safe or cold boot. An illegal request leaves the state unchanged. It sets `illegal_seen` on the next edge, and `illegal_seen` stays 1 until `rst_n` is low.
- R10: `state` reports off=0, safe=1, cold boot=2, warm boot=3, operational=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_on | input | 1 | Supply present |
| por | input | 1 | Power-on reset asserted (active high) |
| vmon_ok | input | 1 | Supply monitor reports in range |
| cold_done | input | 1 | Cold boot finished pulse |
| sw_init_done | input | 1 | Software initialisation complete strobe |
| warm_req | input | NUM_WRQ | Warm-reset request lines, any bit counts |
| state | output | 3 | Current state code |
| warm_rst | output | 1 | Internal warm reset, active high |
| cpu_en | output | 1 | CPU enable |
| io_hiz | output | 1 | Pins tri-stated and input-only |
| illegal_seen | output | 1 | Sticky illegal-request flag |

## Verification
A wrong state shows on the `state` code in the same cycle the register takes it. At that point `warm_rst`, `cpu_en` and `io_hiz` disagree with the expected decode. A lost or extra move is therefore visible one edge after the inputs that should or should not have caused it. A mishandled illegal request shows one edge later on `illegal_seen`, and that error never clears until reset. A reference model in the bench tracks the expected state and flag. Every output is compared with it on each cycle, so a divergence is caught within one clock of the faulty move.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    localparam int LC_W = 3;
    typedef enum logic [LC_W-1:0] {
        LC_OFF  = 3'd0,
        LC_SAFE = 3'd1,
        LC_COLD = 3'd2,
        LC_WARM = 3'd3,
        LC_OPER = 3'd4
    } lc_state_t;
endpackage

// File: rtl/lcs_req_check.sv
module lcs_req_check
    import lcs_pkg::*;
#(
    parameter int NUM_WRQ = 2
) (
    input  lc_state_t          cur,
    input  logic               cold_done,
    input  logic               sw_init_done,
    input  logic [NUM_WRQ-1:0] warm_req,
    output logic               wrq_any,
    output logic               illegal_hit
);
    logic cold_bad, sw_bad, wrq_bad;

    assign wrq_any = |warm_req;

    always_comb begin
        cold_bad = cold_done && (cur != LC_COLD);
        sw_bad   = sw_init_done && (cur != LC_WARM);
        unique case (cur)
            LC_OFF, LC_SAFE, LC_COLD: wrq_bad = wrq_any;
            default:                  wrq_bad = 1'b0;
        endcase
        illegal_hit = cold_bad | sw_bad | wrq_bad;
    end
endmodule

// File: rtl/lcs_fsm.sv
module lcs_fsm
    import lcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_on,
    input  logic      por,
    input  logic      vmon_ok,
    input  logic      cold_done,
    input  logic      sw_init_done,
    input  logic      wrq_any,
    output lc_state_t state_q
);
    lc_state_t state_d;
    logic      force_safe;

    assign force_safe = !supply_on || por || !vmon_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LC_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LC_OFF: begin
                if (supply_on) state_d = LC_SAFE;
            end
            LC_SAFE: begin
                if (!supply_on)      state_d = LC_OFF;
                else if (!force_safe) state_d = LC_COLD;
            end
            LC_COLD: begin
                if (force_safe)     state_d = LC_SAFE;
                else if (cold_done) state_d = LC_WARM;
            end
            LC_WARM: begin
                if (force_safe)        state_d = LC_SAFE;
                else if (sw_init_done) state_d = LC_OPER;
            end
            LC_OPER: begin
                if (force_safe)   state_d = LC_SAFE;
                else if (wrq_any) state_d = LC_WARM;
            end
            default: state_d = LC_SAFE;
        endcase
    end

    // R2
    off_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LC_OFF && $past(state_q) != LC_OFF) |-> ($past(state_q) == LC_SAFE));

    // R4
    force_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LC_COLD || state_q == LC_WARM || state_q == LC_OPER) && (por || !vmon_ok || !supply_on))
        |=> (state_q == LC_SAFE));

    // R5
    cold_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LC_COLD && cold_done && supply_on && !por && vmon_ok) |=> (state_q == LC_WARM));

    // R6
    warm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == LC_WARM && state_q == LC_OPER) |-> $past(sw_init_done));

    // R7
    oper_wreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LC_OPER && wrq_any && supply_on && !por && vmon_ok) |=> (state_q == LC_WARM));
endmodule

// File: rtl/lcs_out_dec.sv
module lcs_out_dec
    import lcs_pkg::*;
(
    input  lc_state_t cur,
    output logic      warm_rst,
    output logic      cpu_en,
    output logic      io_hiz
);
    always_comb begin
        unique case (cur)
            LC_WARM, LC_OPER: begin
                warm_rst = 1'b0;
                cpu_en   = 1'b1;
                io_hiz   = 1'b0;
            end
            default: begin
                warm_rst = 1'b1;
                cpu_en   = 1'b0;
                io_hiz   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dev_lifecycle_ctrl.sv
module dev_lifecycle_ctrl
    import lcs_pkg::*;
#(
    parameter int NUM_WRQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_on,
    input  logic               por,
    input  logic               vmon_ok,
    input  logic               cold_done,
    input  logic               sw_init_done,
    input  logic [NUM_WRQ-1:0] warm_req,
    output logic [LC_W-1:0]    state,
    output logic               warm_rst,
    output logic               cpu_en,
    output logic               io_hiz,
    output logic               illegal_seen
);
    lc_state_t cur;
    logic      wrq_any;
    logic      illegal_hit;
    logic      illegal_q;

    lcs_req_check #(.NUM_WRQ(NUM_WRQ)) u_chk (
        .cur          (cur),
        .cold_done    (cold_done),
        .sw_init_done (sw_init_done),
        .warm_req     (warm_req),
        .wrq_any      (wrq_any),
        .illegal_hit  (illegal_hit)
    );

    lcs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_on    (supply_on),
        .por          (por),
        .vmon_ok      (vmon_ok),
        .cold_done    (cold_done),
        .sw_init_done (sw_init_done),
        .wrq_any      (wrq_any),
        .state_q      (cur)
    );

    lcs_out_dec u_dec (
        .cur      (cur),
        .warm_rst (warm_rst),
        .cpu_en   (cpu_en),
        .io_hiz   (io_hiz)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           illegal_q <= 1'b0;
        else if (illegal_hit) illegal_q <= 1'b1;
    end

    assign state        = cur;
    assign illegal_seen = illegal_q;

    // R9
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> illegal_q);

    // R8
    wrst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_rst) |-> (cur == LC_WARM && $past(cur) == LC_COLD || $past(cur) == LC_OPER || cur == LC_WARM));
endmodule

// File: tb/sim_dev_lifecycle_ctrl.sv
`timescale 1ns/1ps
module sim_dev_lifecycle_ctrl;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_on = 1'b0, por = 1'b0, vmon_ok = 1'b0;
    logic          cold_done = 1'b0, sw_init_done = 1'b0;
    logic [NW-1:0] warm_req = '0;
    logic [2:0]    state;
    logic          warm_rst, cpu_en, io_hiz, illegal_seen;

    int    n_chk = 0, n_bad = 0;
    int    es = 0;
    bit    eill = 1'b0;
    string etag = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    dev_lifecycle_ctrl #(.NUM_WRQ(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_on(supply_on), .por(por), .vmon_ok(vmon_ok),
        .cold_done(cold_done), .sw_init_done(sw_init_done), .warm_req(warm_req),
        .state(state), .warm_rst(warm_rst), .cpu_en(cpu_en), .io_hiz(io_hiz),
        .illegal_seen(illegal_seen)
    );

    // reference model: codes off 0, safe 1, cold 2, warm 3, oper 4
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            es = 0; eill = 1'b0; etag = "R1";
        end else begin
            bit frc, wr, bad;
            frc = !supply_on || por || !vmon_ok;
            wr  = |warm_req;
            bad = (cold_done && es != 2) || (sw_init_done && es != 3) || (wr && es <= 2);
            if (bad) eill = 1'b1;
            if (es == 0) begin
                if (supply_on) begin es = 1; etag = "R2"; end
            end else if (es == 1) begin
                if (!supply_on) begin es = 0; etag = "R2"; end
                else if (!frc) begin es = 2; etag = "R3"; end
                else etag = "R3";
            end else if (frc) begin
                es = 1; etag = "R4";
            end else if (es == 2) begin
                if (cold_done) es = 3;
                etag = "R5";
            end else if (es == 3) begin
                if (sw_init_done) es = 4;
                etag = "R6";
            end else begin
                if (wr) es = 3;
                etag = "R7";
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            bit on;
            on = (es == 3 || es == 4);
            chk(int'(state), es, {etag, " R10 state"});
            chk(int'(warm_rst), int'(!on), "R8 warm_rst");
            chk(int'(cpu_en), int'(on), "R8 cpu_en");
            chk(int'(io_hiz), int'(!on), "R8 io_hiz");
            chk(int'(illegal_seen), int'(eill), "R9 illegal_seen");
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #0.5;
    endtask

    task automatic pulse_cold();
        cold_done = 1'b1; cyc(1); cold_done = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_init_done = 1'b1; cyc(1); sw_init_done = 1'b0;
    endtask

    task automatic power_to_oper();
        supply_on = 1'b1; por = 1'b0; vmon_ok = 1'b1;
        cyc(3);
        pulse_cold(); cyc(1);
        pulse_sw(); cyc(1);
    endtask

    initial begin : watchdog
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(3);
        chk(int'(state), 0, "R1 state");
        chk(int'(warm_rst), 1, "R1 warm_rst");
        chk(int'(io_hiz), 1, "R1 io_hiz");
        chk(int'(cpu_en), 0, "R1 cpu_en");
        chk(int'(illegal_seen), 0, "R1 flag");
        rst_n = 1'b1;
        cyc(3);
        // R2 off to safe, R3 hold under por then vmon low
        supply_on = 1'b1; por = 1'b1;
        cyc(3);
        chk(int'(state), 1, "R3 hold por");
        por = 1'b0; vmon_ok = 1'b0;
        cyc(3);
        chk(int'(state), 1, "R3 hold vmon");
        vmon_ok = 1'b1;
        cyc(3);
        chk(int'(state), 2, "R3 to cold");
        // R5 cold to warm, R6 warm req legal in warm
        pulse_cold(); cyc(1);
        chk(int'(state), 3, "R5 warm");
        warm_req = 2'b10; cyc(2); warm_req = '0;
        chk(int'(state), 3, "R6 warm hold");
        chk(int'(illegal_seen), 0, "R6 no flag");
        pulse_sw(); cyc(1);
        chk(int'(state), 4, "R6 oper");
        // R7 warm req over sw strobe, sw illegal in oper -> R9
        warm_req = 2'b01; sw_init_done = 1'b1; cyc(1);
        warm_req = '0; sw_init_done = 1'b0; cyc(1);
        chk(int'(state), 3, "R7 back to warm");
        chk(int'(illegal_seen), 1, "R9 flag set");
        cyc(4);
        chk(int'(illegal_seen), 1, "R9 flag sticky");
        // R9 clear by reset
        rst_n = 1'b0; cyc(2);
        chk(int'(illegal_seen), 0, "R9 cleared");
        rst_n = 1'b1;
        power_to_oper();
        chk(int'(state), 4, "R6 oper again");
        // R4 por in oper
        por = 1'b1; cyc(1);
        chk(int'(state), 1, "R4 por forces safe");
        por = 1'b0; cyc(2);
        // R4 vmon low in cold
        vmon_ok = 1'b0; cyc(1);
        chk(int'(state), 1, "R4 vmon forces safe");
        vmon_ok = 1'b1; cyc(2);
        // R9 illegal cold_done early, sw in cold, warm_req in cold
        warm_req = 2'b11; cyc(1); warm_req = '0;
        chk(int'(state), 2, "R9 ignored warm_req");
        pulse_sw();
        chk(int'(state), 2, "R9 ignored sw");
        pulse_cold(); cyc(1);
        // R9 cold_done in warm ignored
        pulse_cold();
        chk(int'(state), 3, "R9 ignored cold_done");
        // R4 supply loss in warm -> safe then off (R2)
        supply_on = 1'b0; cyc(1);
        chk(int'(state), 1, "R4 supply loss to safe");
        cyc(1);
        chk(int'(state), 0, "R2 safe to off");
        cyc(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule